// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hardware, the frequency in hertz of a chosen derived clock of an on-chip clock controller. It does not make any clocks. It reads the controller's configuration fields as plain inputs: the system PLL multiplier select, two 6-bit fractional-divider fields, a 2-bit source select, and three post-divider fields. From these it evaluates the chain PLL → fractional divider → source mux → AHB divider → IPG divider → peripheral divider. Every division in the chain runs on one shared bit-serial divider, one stage after another.

A caller pulses `start` together with a clock identifier. The block copies the identifier and all the configuration fields at that moment and raises `busy`. When the answer is ready it pulses `done` for one cycle and presents a 32-bit result. The result and the error flag stay stable until the next `done`. The reference frequency is 24 MHz, and the intermediate values are 64 bits wide.

Clock identifier encoding, set by this block:

| Code | Clock |
|------|-------|
| 0 | none |
| 1 | IPG clock |
| 2 | peripheral clock |
| 3 | reference clock |
| 4 | reference clock divided by 8 |
| 5 to 7 | unsupported |

Top module: `clkFreqCalc`

## Requirements
- R1: After reset, `busy`, `done`, `fracErr` and `freqHz` are all 0.
- R2: The constant identifiers return their values directly. Code 3 returns 24000000, code 4 returns 3000000, and codes 0, 5, 6 and 7 return 0. For these codes, `done` rises on the first clock edge after the edge that samples `start`.
- R3: With source select 0, the source frequency equals the PLL frequency. The PLL frequency is 24000000 × 22 when `pllSelIn` is 1, and 24000000 × 20 when it is 0.
- R4: Source select 1 gives PLL×18 / `frac2In`. Source select 2 gives PLL×18 / `frac0In`. Source select 3 gives (PLL×18 / `frac2In`) / 2. Each division is an integer division that truncates.
- R5: Code 1 returns source / (1+`ahbDivIn`) / (1+`ipgDivIn`). Code 2 divides that result once more by (1+`perDivIn`). Each stage truncates before the next stage starts, and the final value is the low 32 bits.
- R6: A request on code 1 or 2 fails if the fraction field its source select uses is 0. In that case the request completes with `freqHz` = 0 and `fracErr` = 1, with no hang. A zero fraction field that the source select does not use has no effect.
- R7: `done` lasts exactly one cycle. `busy` is high from the cycle after `start` is accepted until `done`, and is low while `done` is high. A `start` pulse while `busy` is high is ignored and produces no extra `done`.
- R8: Changes to `clkIdIn` or to any configuration input while `busy` is high do not affect the result.
- R9: `freqHz` and `fracErr` hold between `done` pulses. A request that succeeds clears `fracErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| clkIdIn | input | 3 | Requested clock identifier |
| pllSelIn | input | 1 | PLL multiplier select (1: ×22, 0: ×20) |
| frac0In | input | 6 | Fraction field of fractional output 0 |
| frac2In | input | 6 | Fraction field of fractional output 2 |
| preSelIn | input | 2 | Source select |
| ahbDivIn | input | 3 | AHB post-divider field |
| ipgDivIn | input | 2 | IPG post-divider field |
| perDivIn | input | 6 | Peripheral post-divider field |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| freqHz | output | 32 | Computed frequency |
| fracErr | output | 1 | Last result came from a zero fraction field |

## Verification
The assertions assume that `start` is driven as a pulse of one cycle. They also assume that the divider is never started with a zero divisor. Zero-fraction requests are routed to the error path before any division is issued, so the second condition holds for every input pattern.

The stimulus drives all inputs at the falling edge. It includes zero fraction fields on both the selected and the unselected path, all four source selects, and the extreme post-divider values. It also changes the configuration mid-request and sends extra start pulses while `busy` is high; the behaviour expected in those cases is what R7 and R8 describe.

// File: rtl/clkFreqPkg.sv
package clkFreqPkg;
  localparam logic [2:0] ID_NONE    = 3'd0;
  localparam logic [2:0] ID_IPG     = 3'd1;
  localparam logic [2:0] ID_PER     = 3'd2;
  localparam logic [2:0] ID_HIGH    = 3'd3;
  localparam logic [2:0] ID_HIGHDIV = 3'd4;

  typedef enum logic [1:0] {STG_FRAC, STG_AHB, STG_IPG, STG_PER} stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;
    logic   seedPll;
    logic   divGo;
    logic   accFromDiv;
    logic   finish;
    logic   useConst;
    logic   flagErr;
    stage_e stage;
  } ctrlStrb_t;

  // snapshot status from datapath to control
  typedef struct packed {
    logic chain;
    logic needFrac;
    logic fracZero;
    logic perWanted;
  } cfgStat_t;
endpackage

// File: rtl/freqIterDiv.sv
module freqIterDiv #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             fin
);
  localparam int CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic [DVD_W-1:0] qReg;
  logic [DVS_W-1:0] rem, dvsReg;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [DVS_W:0]   shifted;
  logic             fits;

  always_comb begin
    shifted = {rem, qReg[DVD_W-1]};
    fits    = shifted >= {1'b0, dvsReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qReg <= '0; rem <= '0; dvsReg <= '0; cnt <= '0;
      running <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        qReg <= dividend; rem <= '0; dvsReg <= divisor;
        cnt <= '0; running <= 1'b1;
      end else if (running) begin
        rem  <= fits ? DVS_W'(shifted - {1'b0, dvsReg}) : shifted[DVS_W-1:0];
        qReg <= {qReg[DVD_W-2:0], fits};
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign quotient = qReg;

  // R6
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    go |-> divisor != '0);
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !go);
endmodule

// File: rtl/freqCalcCtrl.sv
module freqCalcCtrl
  import clkFreqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  cfgStat_t  stat,
  input  logic      divDone,
  output ctrlStrb_t strb,
  output logic      busy
);
  typedef enum logic [1:0] {C_IDLE, C_DECIDE, C_ISSUE, C_WAIT} cState_e;

  cState_e state, stateNx;
  stage_e  stage, stageNx;

  always_comb begin
    stateNx = state;
    stageNx = stage;
    strb    = '0;
    strb.stage = stage;
    unique case (state)
      C_IDLE: if (start) begin
        strb.capture = 1'b1;
        stateNx = C_DECIDE;
      end
      C_DECIDE: begin
        if (!stat.chain) begin
          strb.finish = 1'b1; strb.useConst = 1'b1; stateNx = C_IDLE;
        end else if (stat.needFrac && stat.fracZero) begin
          strb.finish = 1'b1; strb.flagErr = 1'b1; stateNx = C_IDLE;
        end else if (stat.needFrac) begin
          stageNx = STG_FRAC; stateNx = C_ISSUE;
        end else begin
          strb.seedPll = 1'b1; stageNx = STG_AHB; stateNx = C_ISSUE;
        end
      end
      C_ISSUE: begin
        strb.divGo = 1'b1;
        stateNx = C_WAIT;
      end
      C_WAIT: if (divDone) begin
        strb.accFromDiv = 1'b1;
        if (stage == STG_PER || (stage == STG_IPG && !stat.perWanted)) begin
          strb.finish = 1'b1; stateNx = C_IDLE;
        end else begin
          stageNx = (stage == STG_FRAC) ? STG_AHB :
                    (stage == STG_AHB)  ? STG_IPG : STG_PER;
          stateNx = C_ISSUE;
        end
      end
      default: stateNx = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= C_IDLE;
      stage <= STG_FRAC;
    end else begin
      state <= stateNx;
      stage <= stageNx;
    end
  end

  assign busy = state != C_IDLE;

  // R7
  wait_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.divGo |=> state == C_WAIT);
endmodule

// File: rtl/freqCalcDpath.sv
module freqCalcDpath
  import clkFreqPkg::*;
#(
  parameter int REF_HZ  = 24000000,
  parameter int PLL_HI  = 22,
  parameter int PLL_LO  = 20,
  parameter int FRAC_K  = 18,
  parameter int FRAC_W  = 6,
  parameter int AHB_W   = 3,
  parameter int IPG_W   = 2,
  parameter int PER_W   = 6,
  parameter int DIV_W   = 64,
  parameter int OUT_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [2:0]       clkIdIn,
  input  logic             pllSelIn,
  input  logic [FRAC_W-1:0] frac0In,
  input  logic [FRAC_W-1:0] frac2In,
  input  logic [1:0]       preSelIn,
  input  logic [AHB_W-1:0] ahbDivIn,
  input  logic [IPG_W-1:0] ipgDivIn,
  input  logic [PER_W-1:0] perDivIn,
  output cfgStat_t         stat,
  output logic             divDone,
  output logic             done,
  output logic [OUT_W-1:0] freqHz,
  output logic             fracErr
);
  localparam int MAXF  = (FRAC_W > AHB_W) ? FRAC_W : AHB_W;
  localparam int MAXG  = (MAXF > PER_W) ? MAXF : PER_W;
  localparam int DVS_W = MAXG + 1;
  localparam logic [DIV_W-1:0] REF_W = DIV_W'(REF_HZ);

  logic [2:0]        sId;
  logic              sPllSel;
  logic [FRAC_W-1:0] sFrac0, sFrac2, fracSel;
  logic [1:0]        sPre;
  logic [AHB_W-1:0]  sAhb;
  logic [IPG_W-1:0]  sIpg;
  logic [PER_W-1:0]  sPer;
  logic [DIV_W-1:0]  acc, pll, dividend, quotient;
  logic [DVS_W-1:0]  divisor;
  logic [OUT_W-1:0]  constVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sId <= '0; sPllSel <= 1'b0; sFrac0 <= '0; sFrac2 <= '0;
      sPre <= '0; sAhb <= '0; sIpg <= '0; sPer <= '0;
    end else if (strb.capture) begin
      sId <= clkIdIn; sPllSel <= pllSelIn; sFrac0 <= frac0In; sFrac2 <= frac2In;
      sPre <= preSelIn; sAhb <= ahbDivIn; sIpg <= ipgDivIn; sPer <= perDivIn;
    end
  end

  always_comb begin
    pll      = sPllSel ? REF_W * DIV_W'(PLL_HI) : REF_W * DIV_W'(PLL_LO);
    fracSel  = (sPre == 2'd2) ? sFrac0 : sFrac2;
    stat.chain     = (sId == ID_IPG) || (sId == ID_PER);
    stat.perWanted = sId == ID_PER;
    stat.needFrac  = sPre != 2'd0;
    stat.fracZero  = fracSel == '0;
    unique case (strb.stage)
      STG_FRAC: divisor = DVS_W'(fracSel);
      STG_AHB:  divisor = DVS_W'(sAhb) + DVS_W'(1);
      STG_IPG:  divisor = DVS_W'(sIpg) + DVS_W'(1);
      default:  divisor = DVS_W'(sPer) + DVS_W'(1);
    endcase
    dividend = (strb.stage == STG_FRAC) ? pll * DIV_W'(FRAC_K) : acc;
    unique case (sId)
      ID_HIGH:    constVal = OUT_W'(REF_HZ);
      ID_HIGHDIV: constVal = OUT_W'(REF_HZ / 8);
      default:    constVal = '0;
    endcase
  end

  freqIterDiv #(.DVD_W(DIV_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rstN(rstN), .go(strb.divGo), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .fin(divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; done <= 1'b0; freqHz <= '0; fracErr <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.seedPll) acc <= pll;
      else if (strb.accFromDiv)
        acc <= (strb.stage == STG_FRAC && sPre == 2'd3) ? quotient >> 1 : quotient;
      if (strb.finish) begin
        fracErr <= strb.flagErr;
        freqHz  <= strb.flagErr ? '0 : strb.useConst ? constVal : quotient[OUT_W-1:0];
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(freqHz) && $stable(fracErr));
  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(sId) && $stable(sPre) && $stable(sFrac2));
endmodule

// File: rtl/clkFreqCalc.sv
module clkFreqCalc
  import clkFreqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  clkIdIn,
  input  logic        pllSelIn,
  input  logic [5:0]  frac0In,
  input  logic [5:0]  frac2In,
  input  logic [1:0]  preSelIn,
  input  logic [2:0]  ahbDivIn,
  input  logic [1:0]  ipgDivIn,
  input  logic [5:0]  perDivIn,
  output logic        busy,
  output logic        done,
  output logic [31:0] freqHz,
  output logic        fracErr
);
  ctrlStrb_t strb;
  cfgStat_t  stat;
  logic      divDone;

  freqCalcCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .divDone(divDone), .strb(strb), .busy(busy)
  );

  freqCalcDpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .clkIdIn(clkIdIn),
    .pllSelIn(pllSelIn), .frac0In(frac0In), .frac2In(frac2In),
    .preSelIn(preSelIn), .ahbDivIn(ahbDivIn), .ipgDivIn(ipgDivIn),
    .perDivIn(perDivIn), .stat(stat), .divDone(divDone), .done(done),
    .freqHz(freqHz), .fracErr(fracErr)
  );

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R6
  err_only_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fracErr) |-> done);
endmodule

// File: tb/clkFreqCalc_tb.sv
`timescale 1ns/1ps
module clkFreqCalc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  clkIdIn = '0;
  logic        pllSelIn = 1'b0;
  logic [5:0]  frac0In = '0, frac2In = '0, perDivIn = '0;
  logic [1:0]  preSelIn = '0, ipgDivIn = '0;
  logic [2:0]  ahbDivIn = '0;
  logic        busy, done, fracErr;
  logic [31:0] freqHz;

  int errors = 0;
  int checks = 0;
  int pending = 0;
  longint cycles = 0;

  always #2 clk = ~clk;

  clkFreqCalc u_dut (
    .clk(clk), .rstN(rstN), .start(start), .clkIdIn(clkIdIn),
    .pllSelIn(pllSelIn), .frac0In(frac0In), .frac2In(frac2In),
    .preSelIn(preSelIn), .ahbDivIn(ahbDivIn), .ipgDivIn(ipgDivIn),
    .perDivIn(perDivIn), .busy(busy), .done(done), .freqHz(freqHz),
    .fracErr(fracErr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  function automatic longint model(input int id, input bit ps, input int f0,
      input int f2, input int sel, input int a, input int i, input int p,
      output bit err);
    longint pll, src;
    err = 0;
    if (id == 3) return 24000000;
    if (id == 4) return 3000000;
    if (id != 1 && id != 2) return 0;
    pll = 64'd24000000 * (ps ? 22 : 20);
    case (sel)
      0: src = pll;
      1: begin if (f2 == 0) begin err = 1; return 0; end src = pll * 18 / f2; end
      2: begin if (f0 == 0) begin err = 1; return 0; end src = pll * 18 / f0; end
      default: begin if (f2 == 0) begin err = 1; return 0; end src = (pll * 18 / f2) / 2; end
    endcase
    src = src / (1 + a);
    src = src / (1 + i);
    if (id == 2) src = src / (1 + p);
    return src & 64'hFFFF_FFFF;
  endfunction

  // per-clock monitor: done only when a request is outstanding (R7)
  always @(negedge clk) begin
    cycles++;
    if (rstN && done) begin
      check("R7 done without request", pending, 1);
      pending = 0;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic issue(input int id);
    @(negedge clk);
    clkIdIn = 3'(id); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pending = 1;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    ok = 0;
    while (n < 2000) begin
      @(posedge clk); #1;
      if (done) begin ok = 1; return; end
      n++;
    end
    check("R6 hang", 1, 0);
  endtask

  task automatic runReq(input string req, input int id, input bit ps,
      input int f0, input int f2, input int sel, input int a, input int i,
      input int p);
    bit e, ok;
    longint exp;
    pllSelIn = ps; frac0In = 6'(f0); frac2In = 6'(f2); preSelIn = 2'(sel);
    ahbDivIn = 3'(a); ipgDivIn = 2'(i); perDivIn = 6'(p);
    exp = model(id, ps, f0, f2, sel, a, i, p, e);
    issue(id);
    waitDone(ok);
    if (ok) begin
      check({req, " value"}, freqHz, exp);
      check({req, " err"}, fracErr, e);
    end
  endtask

  initial begin
    bit ok, e;
    longint exp, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 freq", freqHz, 0);
    check("R1 err", fracErr, 0);
    rstN = 1'b1;

    // R2 constant ids and their latency
    @(negedge clk);
    clkIdIn = 3'd3; start = 1'b1;
    @(posedge clk); pending = 1;
    @(negedge clk); start = 1'b0;
    check("R7 busy after accept", busy, 1);
    @(posedge clk); #1;
    check("R2 latency done", done, 1);
    check("R2 high", freqHz, 24000000);
    check("R7 busy low at done", busy, 0);
    runReq("R2 highdiv", 4, 0, 1, 1, 0, 0, 0, 0);
    runReq("R2 none", 0, 0, 1, 1, 0, 0, 0, 0);
    runReq("R2 unsup5", 5, 1, 1, 1, 0, 0, 0, 0);
    runReq("R2 unsup7", 7, 1, 1, 1, 0, 0, 0, 0);

    // R3 PLL source
    runReq("R3 pll22 ipg", 1, 1, 0, 0, 0, 0, 0, 0);
    runReq("R3 pll20 ipg", 1, 0, 0, 0, 0, 0, 0, 0);
    // R4 fractional sources
    runReq("R4 sel1", 1, 1, 5, 27, 1, 0, 0, 0);
    runReq("R4 sel2", 1, 1, 24, 35, 2, 0, 0, 0);
    runReq("R4 sel3", 1, 0, 24, 17, 3, 0, 0, 0);
    runReq("R4 sel2 f0=1", 1, 1, 1, 0, 2, 0, 0, 0);
    // R5 post-divider chain
    runReq("R5 ipg", 1, 1, 0, 27, 1, 3, 1, 0);
    runReq("R5 per", 2, 1, 0, 27, 1, 3, 1, 5);
    runReq("R5 per max", 2, 1, 63, 63, 3, 7, 3, 63);
    runReq("R5 per trunc", 2, 0, 13, 29, 2, 6, 2, 40);
    runReq("R5 per sel0", 2, 0, 0, 0, 0, 2, 3, 11);
    // R6 zero fraction
    runReq("R6 f2 zero sel1", 1, 1, 9, 0, 1, 0, 0, 0);
    runReq("R6 f0 zero sel2", 2, 1, 0, 9, 2, 1, 1, 1);
    runReq("R6 f2 zero sel3", 2, 0, 9, 0, 3, 1, 1, 1);
    runReq("R6 unused zero", 1, 1, 0, 20, 1, 1, 1, 0);
    // R9 err cleared by a good request
    runReq("R9 clear", 3, 0, 0, 0, 0, 0, 0, 0);

    // R7 start while busy ignored; R8 config changes ignored
    pllSelIn = 1; frac0In = 6'd30; frac2In = 6'd19; preSelIn = 2'd1;
    ahbDivIn = 3'd2; ipgDivIn = 2'd1; perDivIn = 6'd7;
    exp = model(2, 1, 30, 19, 1, 2, 1, 7, e);
    issue(2);
    repeat (10) @(negedge clk);
    pllSelIn = 0; frac2In = 6'd0; preSelIn = 2'd3; ahbDivIn = 3'd7; perDivIn = 6'd0;
    clkIdIn = 3'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone(ok);
    if (ok) begin
      check("R8 value", freqHz, exp);
      check("R8 err", fracErr, 0);
    end
    held = freqHz;
    repeat (400) @(negedge clk);
    check("R7 no extra done", done, 0);
    check("R9 held", freqHz, held);
    check("R7 idle", busy, 0);

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule